// File: doc/BRIEF.md
# Dual-Table Logic Slice with Shared Combiner

This block is one programmable logic tile. Two K-input lookup tables (the "first" and "second" tables, 16 entries each at the default K=4) evaluate arbitrary functions of their own address inputs. A third, 8-entry table combines both results with one extra input, `hx_in`. This gives two independent functions of up to K inputs each, or one wider function of up to 2K+1 inputs.

Two combinational outputs each pick either their own table's result or the combiner's result. Two registered outputs each capture one of four sources: the data input, the first result, the second result, or the combiner result. The registers have a shared clock enable. They also have a shared asynchronous set/reset, and the value it forces is chosen per register by configuration.

All table contents and control fields sit in one configuration register that is loaded serially. A RAM mode turns the two K-input tables into two 2^K x 1 memories. These memories are written synchronously and read asynchronously through the normal outputs.

Top module: `lut_slice`

## Requirements
- R1: While `rst_n` is low, the configuration register and both output registers are cleared, so `xo`, `yo`, `xq` and `yq` are all 0.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_sin` into the top of the 49-bit configuration register and moves every bit one place down, so the first bit sent ends in bit 0.
  - The layout from bit 0 upward is: first table (16 bits), second table (16), combiner table (8), `x_use_comb`, `y_use_comb`, x source (2 bits), y source (2), x set-value, y set-value, ram mode.
- R3: The first result is first-table bit number `fa_in`, and the second result is second-table bit number `ga_in`. When its select bit is 0, `xo` shows the first result and `yo` shows the second.
- R4: The combiner result is combiner-table bit number {hx_in, second result, first result}, with `hx_in` as the most significant bit. When its select bit is 1, `xo` (or `yo`) shows the combiner result.
- R5: On a rising edge with `ce` high and `srst` low, each output register captures its source. Source code 0 is `dat_in`, 1 is the first result, 2 is the second result and 3 is the combiner result.
- R6: On a rising edge with `ce` low and `srst` low, both output registers keep their values.
- R7: `srst` high forces each output register at once, without waiting for a clock edge, to its set-value bit (1 presets, 0 clears). It holds that value across clock edges even when `ce` is high.
- R8: When ram mode is 1, `ram_we` is high and `cfg_en` is low, a rising edge writes `dat_in` to first-table entry `fa_in` and `hx_in` to second-table entry `ga_in`. Reads through `xo`/`yo` follow the addresses with no clock.
- R9: When ram mode is 0, `ram_we` has no effect on the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Serial configuration data |
| fa_in | input | K | First table address |
| ga_in | input | K | Second table address |
| hx_in | input | 1 | Extra combiner input, second-table write data in RAM mode |
| dat_in | input | 1 | Register data source, first-table write data in RAM mode |
| ram_we | input | 1 | Table write enable in RAM mode |
| srst | input | 1 | Asynchronous set/reset of the output registers |
| ce | input | 1 | Output register clock enable |
| xo | output | 1 | Combinational output X |
| yo | output | 1 | Combinational output Y |
| xq | output | 1 | Registered output X |
| yq | output | 1 | Registered output Y |

## Verification
The bench builds the slice with its default K=4. This makes every entry of the 16-entry tables reachable from the address ports, and the full 49-bit configuration stream short enough to reload it for each register source code. The first table is swept over all 16 addresses, and the combiner over 32 input patterns that cover both values of `hx_in`. The set/reset is checked between clock edges to show its asynchronous action, and again across an enabled edge to show its priority. RAM mode is checked with reads before and after a write and at a neighbouring address; with RAM mode off, a write strobe must leave the tables unchanged.

// File: rtl/lutblk_pkg.sv
package lutblk_pkg;

  typedef enum logic [1:0] {
    SRC_DIN  = 2'd0,
    SRC_F    = 2'd1,
    SRC_G    = 2'd2,
    SRC_COMB = 2'd3
  } ff_src_e;

  localparam int COMB_BITS = 8;
  localparam int CTRL_BITS = 9;

  function automatic logic pick_src(ff_src_e s, logic din, logic f, logic g, logic h);
    case (s)
      SRC_DIN: return din;
      SRC_F:   return f;
      SRC_G:   return g;
      default: return h;
    endcase
  endfunction

  function automatic logic [2:0] comb_index(logic hx, logic g, logic f);
    return {hx, g, f};
  endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int K = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_sin,
  input  logic                 ram_wr,
  input  logic [K-1:0]         f_addr,
  input  logic [K-1:0]         g_addr,
  input  logic                 f_wdat,
  input  logic                 g_wdat,
  output logic [2*(1<<K)+lutblk_pkg::COMB_BITS+lutblk_pkg::CTRL_BITS-1:0] cfg_q
);
  localparam int T     = 1 << K;
  localparam int CFG_W = 2*T + lutblk_pkg::COMB_BITS + lutblk_pkg::CTRL_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= {cfg_sin, cfg_q[CFG_W-1:1]};
    end else if (ram_wr) begin
      cfg_q[int'(f_addr)]     <= f_wdat;
      cfg_q[T + int'(g_addr)] <= g_wdat;
    end
  end
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic [K-1:0]      idx,
  output logic              res
);
  assign res = tbl[idx];
endmodule

// File: rtl/out_reg.sv
module out_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst,
  input  logic                ce,
  input  logic                set_val,
  input  lutblk_pkg::ff_src_e src,
  input  logic                din,
  input  logic                f_val,
  input  logic                g_val,
  input  logic                h_val,
  output logic                d_sel,
  output logic                q
);
  always_comb d_sel = lutblk_pkg::pick_src(src, din, f_val, g_val, h_val);

  always_ff @(posedge clk or negedge rst_n or posedge srst) begin
    if (!rst_n)    q <= 1'b0;
    else if (srst) q <= set_val;
    else if (ce)   q <= d_sel;
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_sin,
  input  logic [K-1:0] fa_in,
  input  logic [K-1:0] ga_in,
  input  logic         hx_in,
  input  logic         dat_in,
  input  logic         ram_we,
  input  logic         srst,
  input  logic         ce,
  output logic         xo,
  output logic         yo,
  output logic         xq,
  output logic         yq
);
  import lutblk_pkg::*;

  localparam int T     = 1 << K;
  localparam int HB    = 2*T;
  localparam int C     = HB + COMB_BITS;
  localparam int CFG_W = C + CTRL_BITS;

  // named internal events for the checker
  logic [CFG_W-1:0] cfg_q;
  logic             f_res, g_res, h_res;
  logic             x_use_comb, y_use_comb, ram_mode, ram_wr;
  logic [1:0]       ff_set, ff_d, ff_q;
  ff_src_e          ff_src [2];

  assign x_use_comb = cfg_q[C];
  assign y_use_comb = cfg_q[C+1];
  assign ff_src[0]  = ff_src_e'(cfg_q[C+3:C+2]);
  assign ff_src[1]  = ff_src_e'(cfg_q[C+5:C+4]);
  assign ff_set[0]  = cfg_q[C+6];
  assign ff_set[1]  = cfg_q[C+7];
  assign ram_mode   = cfg_q[C+8];
  assign ram_wr     = ram_mode & ram_we & ~cfg_en;

  cfg_store #(.K(K)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
    .ram_wr(ram_wr), .f_addr(fa_in), .g_addr(ga_in),
    .f_wdat(dat_in), .g_wdat(hx_in), .cfg_q(cfg_q)
  );

  lut_read #(.K(K)) u_f (.tbl(cfg_q[T-1:0]),  .idx(fa_in), .res(f_res));
  lut_read #(.K(K)) u_g (.tbl(cfg_q[HB-1:T]), .idx(ga_in), .res(g_res));
  lut_read #(.K(3)) u_h (.tbl(cfg_q[C-1:HB]),
                         .idx(comb_index(hx_in, g_res, f_res)), .res(h_res));

  assign xo = x_use_comb ? h_res : f_res;
  assign yo = y_use_comb ? h_res : g_res;

  for (genvar i = 0; i < 2; i++) begin : g_ff
    out_reg u_ff (
      .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
      .set_val(ff_set[i]), .src(ff_src[i]), .din(dat_in),
      .f_val(f_res), .g_val(g_res), .h_val(h_res),
      .d_sel(ff_d[i]), .q(ff_q[i])
    );
  end

  assign xq = ff_q[0];
  assign yq = ff_q[1];
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk #(
  parameter int K = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_en,
  input logic                     cfg_sin,
  input logic [2*(1<<K)+16:0]     cfg_q,
  input logic                     ram_wr,
  input logic [K-1:0]             fa_in,
  input logic                     dat_in,
  input logic                     srst,
  input logic                     ce,
  input logic [1:0]               ff_set,
  input logic [1:0]               ff_d,
  input logic [1:0]               ff_q
);
  localparam int CFG_W = 2*(1<<K) + 17;

  // R2
  cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_q == {$past(cfg_sin), $past(cfg_q[CFG_W-1:1])}));

  // R8
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> (cfg_q[$past(fa_in)] == $past(dat_in)));

  // R5
  ce_capture_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    ce |=> (ff_q == $past(ff_d)));

  // R6
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    !ce |=> $stable(ff_q));

  // R7
  sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !$past(cfg_en)) |-> (ff_q == ff_set));
endmodule

bind lut_slice lut_slice_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
  .cfg_q(cfg_q), .ram_wr(ram_wr), .fa_in(fa_in), .dat_in(dat_in),
  .srst(srst), .ce(ce), .ff_set(ff_set), .ff_d(ff_d), .ff_q(ff_q)
);

// File: tb/tb_lut_slice.sv
module tb_lut_slice;
  localparam int K = 4;
  localparam int CW = 49;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_sin = 1'b0;
  logic [K-1:0] fa_in = '0, ga_in = '0;
  logic hx_in = 1'b0, dat_in = 1'b0, ram_we = 1'b0, srst = 1'b0, ce = 1'b0;
  logic xo, yo, xq, yq;

  lut_slice #(.K(K)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { string req; logic [3:0] exp; logic [3:0] msk; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [CW-1:0] bcfg;

  localparam logic [15:0] FT = 16'hA5C3;
  localparam logic [15:0] GT = 16'h1E78;
  localparam logic [7:0]  HT = 8'hD4;

  function automatic logic [CW-1:0] mk_cfg(logic [15:0] f, logic [15:0] g, logic [7:0] h,
      logic xs, logic ys, logic [1:0] xsrc, logic [1:0] ysrc, logic xset, logic yset, logic ram);
    return {ram, yset, xset, ysrc, xsrc, ys, xs, h, g, f};
  endfunction

  function automatic logic fv(logic [3:0] a); return bcfg[a]; endfunction
  function automatic logic gv(logic [3:0] a); return bcfg[16 + int'(a)]; endfunction
  function automatic logic hv(logic h, logic [3:0] fa, logic [3:0] ga);
    return bcfg[32 + int'({h, gv(ga), fv(fa)})];
  endfunction
  function automatic logic srcv(logic [1:0] s, logic d, logic [3:0] fa, logic [3:0] ga, logic h);
    case (s)
      2'd0: return d;
      2'd1: return fv(fa);
      2'd2: return gv(ga);
      default: return hv(h, fa, ga);
    endcase
  endfunction

  task automatic expect_out(string req, logic [3:0] exp, logic [3:0] msk);
    item_t it;
    it.req = req; it.exp = exp; it.msk = msk;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [3:0] obs;
      it = sb.pop_front();
      obs = {xo, yo, xq, yq};
      checks++;
      if ((obs & it.msk) !== (it.exp & it.msk)) begin
        errors++;
        $display("FAIL %s actual %b expected %b", it.req, obs & it.msk, it.exp & it.msk);
      end
    end
  end

  task automatic load_cfg(input logic [CW-1:0] v);
    cfg_en = 1'b1;
    for (int i = 0; i < CW; i++) begin
      cfg_sin = v[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    bcfg = v;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    expect_out("R1", 4'b0000, 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: own-table outputs over every first-table address
    load_cfg(mk_cfg(FT, GT, HT, 0, 0, 2'd0, 2'd0, 0, 0, 0));
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      fa_in = 4'(a); ga_in = 4'(15 - a);
      expect_out((a == 0) ? "R2" : "R3", {fv(fa_in), gv(ga_in), 2'b00}, 4'b1100);
    end

    // R4: combiner selected on both outputs
    load_cfg(mk_cfg(FT, GT, HT, 1, 1, 2'd0, 2'd0, 0, 0, 0));
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      fa_in = 4'(p) ^ 4'h6; ga_in = 4'(p * 7); hx_in = p[4];
      expect_out("R4", {hv(hx_in, fa_in, ga_in), hv(hx_in, fa_in, ga_in), 2'b00}, 4'b1100);
    end

    // R5/R6: every register source code, then hold with ce low
    for (int s = 0; s < 4; s++) begin
      logic d;
      load_cfg(mk_cfg(FT, GT, HT, 0, 0, 2'(s), 2'(s), 0, 0, 0));
      @(negedge clk);
      fa_in = 4'd3 + 4'(s); ga_in = 4'd5 + 4'(s); hx_in = s[0]; dat_in = ~s[1]; ce = 1'b1;
      d = srcv(2'(s), dat_in, fa_in, ga_in, hx_in);
      @(negedge clk);
      expect_out("R5", {2'b00, d, d}, 4'b0011);
      ce = 1'b0; dat_in = ~dat_in; fa_in = ~fa_in; ga_in = ~ga_in; hx_in = ~hx_in;
      @(negedge clk);
      expect_out("R6", {2'b00, d, d}, 4'b0011);
    end

    // R7: asynchronous set/reset and its priority over ce
    load_cfg(mk_cfg(FT, GT, HT, 0, 0, 2'd0, 2'd0, 1, 0, 0));
    @(negedge clk);
    dat_in = 1'b0; ce = 1'b1;
    @(negedge clk);
    expect_out("R5", 4'b0000, 4'b0011);
    @(negedge clk);
    srst = 1'b1;
    expect_out("R7", 4'b0010, 4'b0011);
    dat_in = 1'b1;
    @(negedge clk);
    expect_out("R7", 4'b0010, 4'b0011);
    srst = 1'b0;
    @(negedge clk);
    expect_out("R5", 4'b0011, 4'b0011);
    ce = 1'b0;

    // R8: RAM mode write and asynchronous read
    load_cfg(mk_cfg(16'h0, 16'h0, 8'h0, 0, 0, 2'd0, 2'd0, 0, 0, 1));
    @(negedge clk);
    fa_in = 4'd5; ga_in = 4'd9; dat_in = 1'b1; hx_in = 1'b1; ram_we = 1'b1;
    expect_out("R8", 4'b0000, 4'b1100);
    @(negedge clk);
    ram_we = 1'b0;
    expect_out("R8", 4'b1100, 4'b1100);
    @(negedge clk);
    fa_in = 4'd6;
    expect_out("R8", 4'b0100, 4'b1100);
    @(negedge clk);
    fa_in = 4'd5; dat_in = 1'b0; hx_in = 1'b0; ram_we = 1'b1;
    @(negedge clk);
    ram_we = 1'b0;
    expect_out("R8", 4'b0000, 4'b1100);

    // R9: write strobe ignored outside RAM mode
    load_cfg(mk_cfg(FT, GT, HT, 0, 0, 2'd0, 2'd0, 0, 0, 0));
    @(negedge clk);
    fa_in = 4'd3; ga_in = 4'd0; dat_in = 1'b1; hx_in = 1'b1; ram_we = 1'b1;
    @(negedge clk);
    ram_we = 1'b0;
    expect_out("R9", {FT[3], GT[0], 2'b00}, 4'b1100);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule